// File: doc/BRIEF.md
# Ethernet Interrupt and Event Unit

This unit gathers the event strobes and FIFO levels of an Ethernet controller's MAC and buffer manager into one interrupt status byte. A mask byte selects which status bits drive the single interrupt line. Some status bits follow a live level. Others latch an event and stay set until the host clears them, either by writing 1 to the bit or by issuing a follow-up command.

The unit also holds a 16-bit statistics word made of four 4-bit event counters. When a counter wraps, it sets a rollover flag. That flag, a pending transmit error and a pending link error can each raise the protocol-handler status bit, under three enable bits of a control register. A fatal transmit error clears the transmit-enable flag, and the host must set that flag again. Register bank decoding sits outside the unit: the host side appears here as write strobes with data and a read strobe for the statistics word.

Top module: `eiu_top`

## Requirements
- R1: Status bit 0 shows the `rx_nonempty` level in the same cycle. Bits 6 and 7 always read 0. The bit layout is 0 receive, 1 transmit error, 2 transmit empty, 3 allocation done, 4 receive overrun, 5 protocol handler. The mask uses the same layout and is loaded from `mask_wdata` on `mask_wr`.
- R2: `irq` is high exactly when the bitwise AND of `int_status` and `int_mask` is nonzero.
- R3: Bits 2 (transmit empty) and 4 (receive overrun) are set by `tx_empty_evt` and `rx_ovrn_evt` respectively. Each is cleared by an `ist_wr` whose `ist_wdata` has a 1 at that bit position. Writing 0 to the bit has no effect. If a set and a clear arrive in the same cycle, the set wins.
- R4: Bit 1 is set by `tx_err_evt` and is cleared by an `ist_wr` with `ist_wdata[1]`=1. The set wins over a clear in the same cycle.
- R5: Bit 3 is set by `alloc_done` and cleared by `alloc_cmd`. The set wins when both arrive in the same cycle.
- R6: `stats_word` packs four counters, lowest field first. `[3:0]` counts single collisions (`cnt_evt[0]`), `[7:4]` multiple collisions (`cnt_evt[1]`), `[11:8]` deferred transmits (`cnt_evt[2]`) and `[15:12]` excessively deferred transmits (`cnt_evt[3]`). Each strobe adds 1 to its counter on the next edge.
- R7: A counter at 15 that has not wrapped goes to 0 on its next strobe and sets `rollover`. Once it has wrapped, it counts up to 15 and then holds there.
- R8: `stat_rd` resets all four counters, their wrap state and `rollover` to 0 on the next edge. Counter strobes in that same cycle are dropped.
- R9: Status bit 5 is the OR of three terms: (`te_en` AND a pending transmit error), (`cr_en` AND `rollover`), and (`le_en` AND a pending link error). The enables are loaded on `ctrl_wr` from `ctrl_wdata` bits 5 (`te_en`), 6 (`cr_en`) and 7 (`le_en`).
- R10: `tx_err_evt` clears `tx_enable` and marks a transmit error pending. `txen_set` sets `tx_enable` and clears the pending mark. If both arrive in the same cycle, the error wins.
- R11: `link_err_evt` latches a pending link error. The pending error is cleared by a `ctrl_wr` with `ctrl_wdata[7]`=0, and a new event in the same cycle wins over that clear.
- R12: After reset, all status bits except bit 0 are 0. The mask, the enables, the statistics word, `rollover` and `tx_enable` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_nonempty | input | 1 | Receive FIFO holds a packet (level) |
| tx_err_evt | input | 1 | Fatal transmit error strobe |
| tx_empty_evt | input | 1 | Transmit queue drained strobe |
| alloc_cmd | input | 1 | Host issued an allocate command |
| alloc_done | input | 1 | Pending allocation completed |
| rx_ovrn_evt | input | 1 | Receive overrun strobe |
| link_err_evt | input | 1 | Link error strobe |
| cnt_evt | input | 4 | Statistics event strobes, one per counter |
| txen_set | input | 1 | Host sets transmit enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| ist_wr | input | 1 | Status write (write 1 to clear) strobe |
| ist_wdata | input | 8 | Status write data |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control write data (bits 7:5 used) |
| stat_rd | input | 1 | Statistics word read strobe |
| irq | output | 1 | Interrupt line |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| stats_word | output | 16 | Packed statistics counters |
| rollover | output | 1 | Counter rollover flag |
| tx_enable | output | 1 | Transmit enable flag |

## Verification
The bench checks collisions of set and clear in one cycle on every latched bit: a design that lets the clear win loses an event and never raises the interrupt for it. It drives one counter through a wrap and past 15 again: a wrong design either leaves `rollover` clear or wraps a second time to a small count. It issues a statistics read in the same cycle as counter strobes: a wrong design leaves a stray count or keeps the protocol-handler interrupt alive. It also writes status with zeros in the latched bits, and a careless clear would show there as a dropped bit.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
   localparam int BIT_RX    = 0;
   localparam int BIT_TXERR = 1;
   localparam int BIT_TXEMP = 2;
   localparam int BIT_ALLOC = 3;
   localparam int BIT_OVRN  = 4;
   localparam int BIT_EPH   = 5;
   localparam int NUM_SRC   = 6;

   localparam int CTL_TE = 5;
   localparam int CTL_CR = 6;
   localparam int CTL_LE = 7;

   typedef struct packed {
      logic le;
      logic cr;
      logic te;
   } eph_en_t;
endpackage

// File: rtl/eiu_flag.sv
module eiu_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/eiu_cnt.sv
module eiu_cnt #(
   parameter int CNT_W    = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic wrapped;
   logic at_max;
   logic hold;

   assign at_max = (cnt_o == CMAX);

   generate
      if (SATURATE) begin : g_sat
         assign hold = wrapped & at_max;
      end else begin : g_free
         assign hold = 1'b0;
      end
   endgenerate

   assign wrap_o = inc_i & ~clr_i & at_max & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         wrapped <= 1'b0;
      end else if (clr_i) begin
         cnt_o   <= '0;
         wrapped <= 1'b0;
      end else if (inc_i && !hold) begin
         cnt_o <= cnt_o + 1'b1;
         if (at_max) wrapped <= 1'b1;
      end
   end
endmodule

// File: rtl/eiu_stats.sv
module eiu_stats #(
   parameter int CNT_W    = 4,
   parameter int N_CNT    = 4,
   parameter bit SATURATE = 1'b1,
   localparam int SW      = CNT_W * N_CNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CNT-1:0] evt_i,
   input  logic             rd_i,
   output logic [SW-1:0]    word_o,
   output logic             roll_o
);
   logic [N_CNT-1:0] wrap;

   for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      eiu_cnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc_i (evt_i[i]),
         .clr_i (rd_i),
         .cnt_o (word_o[i*CNT_W +: CNT_W]),
         .wrap_o(wrap[i])
      );
   end

   eiu_flag u_roll (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(|wrap),
      .clr_i(rd_i),
      .q_o  (roll_o)
   );
endmodule

// File: rtl/eiu_top.sv
module eiu_top #(
   parameter int STAT_W   = 8,
   parameter int CNT_W    = 4,
   parameter int N_CNT    = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_nonempty,
   input  logic                     tx_err_evt,
   input  logic                     tx_empty_evt,
   input  logic                     alloc_cmd,
   input  logic                     alloc_done,
   input  logic                     rx_ovrn_evt,
   input  logic                     link_err_evt,
   input  logic [N_CNT-1:0]         cnt_evt,
   input  logic                     txen_set,
   input  logic                     mask_wr,
   input  logic [STAT_W-1:0]        mask_wdata,
   input  logic                     ist_wr,
   input  logic [STAT_W-1:0]        ist_wdata,
   input  logic                     ctrl_wr,
   input  logic [STAT_W-1:0]        ctrl_wdata,
   input  logic                     stat_rd,
   output logic                     irq,
   output logic [STAT_W-1:0]        int_status,
   output logic [STAT_W-1:0]        int_mask,
   output logic [CNT_W*N_CNT-1:0]   stats_word,
   output logic                     rollover,
   output logic                     tx_enable
);
   import eiu_pkg::*;

   localparam int SW = CNT_W * N_CNT;

   generate
      if (STAT_W < NUM_SRC || STAT_W <= CTL_LE) begin : g_bad_w
         $error("eiu_top: STAT_W too narrow for status or control fields");
      end
      if (CNT_W < 2 || N_CNT < 1) begin : g_bad_cnt
         $error("eiu_top: counter geometry invalid");
      end
   endgenerate

   eph_en_t en;
   logic    st_txerr, st_txemp, st_alloc, st_ovrn;
   logic    txerr_pend, link_pend, eph;
   logic    w1c_txerr, w1c_txemp, w1c_ovrn;
   logic    unused_bits;

   assign w1c_txerr = ist_wr & ist_wdata[BIT_TXERR];
   assign w1c_txemp = ist_wr & ist_wdata[BIT_TXEMP];
   assign w1c_ovrn  = ist_wr & ist_wdata[BIT_OVRN];

   eiu_flag u_txerr (.clk(clk), .rst_n(rst_n), .set_i(tx_err_evt),
                     .clr_i(w1c_txerr), .q_o(st_txerr));
   eiu_flag u_txemp (.clk(clk), .rst_n(rst_n), .set_i(tx_empty_evt),
                     .clr_i(w1c_txemp), .q_o(st_txemp));
   eiu_flag u_ovrn  (.clk(clk), .rst_n(rst_n), .set_i(rx_ovrn_evt),
                     .clr_i(w1c_ovrn), .q_o(st_ovrn));
   eiu_flag u_alloc (.clk(clk), .rst_n(rst_n), .set_i(alloc_done),
                     .clr_i(alloc_cmd), .q_o(st_alloc));
   eiu_flag u_tpend (.clk(clk), .rst_n(rst_n), .set_i(tx_err_evt),
                     .clr_i(txen_set), .q_o(txerr_pend));
   eiu_flag u_lpend (.clk(clk), .rst_n(rst_n), .set_i(link_err_evt),
                     .clr_i(ctrl_wr & ~ctrl_wdata[CTL_LE]), .q_o(link_pend));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_mask  <= '0;
         en        <= '0;
         tx_enable <= 1'b0;
      end else begin
         if (mask_wr) int_mask <= mask_wdata;
         if (ctrl_wr) en <= eph_en_t'(ctrl_wdata[CTL_LE:CTL_TE]);
         if (tx_err_evt)    tx_enable <= 1'b0;
         else if (txen_set) tx_enable <= 1'b1;
      end
   end

   eiu_stats #(.CNT_W(CNT_W), .N_CNT(N_CNT), .SATURATE(SATURATE)) u_stats (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (cnt_evt),
      .rd_i  (stat_rd),
      .word_o(stats_word),
      .roll_o(rollover)
   );

   assign eph = (en.te & txerr_pend) | (en.cr & rollover) | (en.le & link_pend);

   always_comb begin
      int_status            = '0;
      int_status[BIT_RX]    = rx_nonempty;
      int_status[BIT_TXERR] = st_txerr;
      int_status[BIT_TXEMP] = st_txemp;
      int_status[BIT_ALLOC] = st_alloc;
      int_status[BIT_OVRN]  = st_ovrn;
      int_status[BIT_EPH]   = eph;
   end

   assign irq = |(int_status & int_mask);

   assign unused_bits = ^{ist_wdata, ctrl_wdata, SW[0]};
endmodule

// File: rtl/eiu_chk.sv
module eiu_chk #(
   parameter int STAT_W = 8,
   parameter int SW     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ist_wr,
   input logic [STAT_W-1:0] ist_wdata,
   input logic              tx_empty_evt,
   input logic              alloc_cmd,
   input logic              alloc_done,
   input logic              stat_rd,
   input logic              tx_err_evt,
   input logic [SW-1:0]     stats_word,
   input logic              rollover,
   input logic              tx_enable,
   input logic [STAT_W-1:0] int_status,
   input logic [STAT_W-1:0] int_mask,
   input logic              irq
);
   AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      int_status[STAT_W-1:6] == '0);                                        // R1
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((int_status & int_mask) != '0));                             // R2
   AST_TXEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      int_status[2] && !(ist_wr && ist_wdata[2]) |=> int_status[2]);        // R3
   AST_TXEMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ist_wr && ist_wdata[2] && !tx_empty_evt |=> !int_status[2]);          // R3
   AST_ALLOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_cmd && !alloc_done |=> !int_status[3]);                         // R5
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (stats_word == '0 && !rollover));                         // R8
   AST_TXEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err_evt |=> !tx_enable);                                           // R10
endmodule

bind eiu_top eiu_chk #(.STAT_W(STAT_W), .SW(CNT_W*N_CNT)) u_chk (.*);

// File: tb/sim_eiu_top.sv
module sim_eiu_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_nonempty, tx_err_evt, tx_empty_evt, alloc_cmd, alloc_done;
   logic rx_ovrn_evt, link_err_evt, txen_set, mask_wr, ist_wr, ctrl_wr, stat_rd;
   logic [3:0]  cnt_evt;
   logic [7:0]  mask_wdata, ist_wdata, ctrl_wdata;
   logic        irq, rollover, tx_enable;
   logic [7:0]  int_status, int_mask;
   logic [15:0] stats_word;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   eiu_top u0 (.*);

   // bench model state
   logic [7:0] m_mask;
   logic       m_txerr, m_txemp, m_alloc, m_ovrn, m_tpend, m_lpend, m_roll, m_txen;
   logic [2:0] m_en;
   logic [3:0] m_c [4];
   logic       m_w [4];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic f_eph();
      return (m_en[0] & m_tpend) | (m_en[1] & m_roll) | (m_en[2] & m_lpend);
   endfunction

   function automatic logic [7:0] f_status();
      return {2'b00, f_eph(), m_ovrn, m_alloc, m_txemp, m_txerr, rx_nonempty};
   endfunction

   function automatic logic [15:0] f_stats();
      return {m_c[3], m_c[2], m_c[1], m_c[0]};
   endfunction

   task automatic model_reset();
      m_mask = 0; m_txerr = 0; m_txemp = 0; m_alloc = 0; m_ovrn = 0;
      m_tpend = 0; m_lpend = 0; m_roll = 0; m_txen = 0; m_en = 0;
      for (int i = 0; i < 4; i++) begin m_c[i] = 0; m_w[i] = 0; end
   endtask

   task automatic model_step();
      if (mask_wr) m_mask = mask_wdata;
      if (tx_err_evt) m_txerr = 1; else if (ist_wr && ist_wdata[1]) m_txerr = 0;
      if (tx_empty_evt) m_txemp = 1; else if (ist_wr && ist_wdata[2]) m_txemp = 0;
      if (rx_ovrn_evt) m_ovrn = 1; else if (ist_wr && ist_wdata[4]) m_ovrn = 0;
      if (alloc_done) m_alloc = 1; else if (alloc_cmd) m_alloc = 0;
      if (link_err_evt) m_lpend = 1; else if (ctrl_wr && !ctrl_wdata[7]) m_lpend = 0;
      if (ctrl_wr) m_en = ctrl_wdata[7:5];
      if (tx_err_evt) begin m_txen = 0; m_tpend = 1; end
      else if (txen_set) begin m_txen = 1; m_tpend = 0; end
      if (stat_rd) begin
         m_roll = 0;
         for (int i = 0; i < 4; i++) begin m_c[i] = 0; m_w[i] = 0; end
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (cnt_evt[i]) begin
               if (m_c[i] == 4'hF) begin
                  if (!m_w[i]) begin m_c[i] = 0; m_w[i] = 1; m_roll = 1; end
               end else m_c[i] = m_c[i] + 1;
            end
         end
      end
   endtask

   task automatic check_all();
      logic [7:0] es;
      es = f_status();
      chk("R1 receive level bit", {31'b0, int_status[0]}, {31'b0, es[0]});
      chk("R1 upper bits zero", {30'b0, int_status[7:6]}, 0);
      chk("R4 tx error bit", {31'b0, int_status[1]}, {31'b0, es[1]});
      chk("R3 tx empty/overrun bits", {30'b0, int_status[4], int_status[2]}, {30'b0, es[4], es[2]});
      chk("R5 alloc bit", {31'b0, int_status[3]}, {31'b0, es[3]});
      chk("R9 protocol handler bit", {31'b0, int_status[5]}, {31'b0, es[5]});
      chk("R2 mask", {24'b0, int_mask}, {24'b0, m_mask});
      chk("R2 irq", {31'b0, irq}, {31'b0, |(es & m_mask)});
      chk("R6 stats word", {16'b0, stats_word}, {16'b0, f_stats()});
      chk("R7 rollover", {31'b0, rollover}, {31'b0, m_roll});
      chk("R10 tx enable", {31'b0, tx_enable}, {31'b0, m_txen});
   endtask

   task automatic idle();
      tx_err_evt = 0; tx_empty_evt = 0; alloc_cmd = 0; alloc_done = 0;
      rx_ovrn_evt = 0; link_err_evt = 0; cnt_evt = 0; txen_set = 0;
      mask_wr = 0; ist_wr = 0; ctrl_wr = 0; stat_rd = 0;
      mask_wdata = 0; ist_wdata = 0; ctrl_wdata = 0;
   endtask

   // inputs set at negedge; commit one edge and check at the next negedge
   task automatic step();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all();
      idle();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      idle();
      rx_nonempty = 0;
      model_reset();
      repeat (3) @(negedge clk);
      check_all();                       // R12 reset state
      chk("R12 reset stats", {16'b0, stats_word}, 0);
      rst_n = 1;
      @(negedge clk);

      // R3: writing zero leaves latched bit set; set wins over clear
      tx_empty_evt = 1; step();
      ist_wr = 1; ist_wdata = 8'hEB; step();
      chk("R3 zero write keeps bit", {31'b0, int_status[2]}, 1);
      ist_wr = 1; ist_wdata = 8'h04; tx_empty_evt = 1; step();
      chk("R3 set beats clear", {31'b0, int_status[2]}, 1);
      ist_wr = 1; ist_wdata = 8'h04; step();
      chk("R3 write one clears", {31'b0, int_status[2]}, 0);

      // R5: alloc set wins over command
      alloc_done = 1; alloc_cmd = 1; step();
      chk("R5 done beats cmd", {31'b0, int_status[3]}, 1);
      alloc_cmd = 1; step();

      // R7/R9: wrap counter 0 with cr enabled and bit 5 unmasked
      ctrl_wr = 1; ctrl_wdata = 8'h40; mask_wr = 1; mask_wdata = 8'h20; step();
      for (int k = 0; k < 16; k++) begin cnt_evt = 4'b0001; step(); end
      chk("R7 wrap to zero", {16'b0, stats_word}, 0);
      chk("R7 rollover raises irq", {31'b0, irq}, 1);
      for (int k = 0; k < 20; k++) begin cnt_evt = 4'b0001; step(); end
      chk("R7 saturate at 15", {16'b0, stats_word}, 16'h000F);

      // R8: read with simultaneous strobes drops them
      stat_rd = 1; cnt_evt = 4'b1111; step();
      chk("R8 read clears", {15'b0, stats_word, irq}, 0);

      // R10/R11: error wins over enable; link pending via enable
      txen_set = 1; step();
      tx_err_evt = 1; txen_set = 1; step();
      chk("R10 error beats enable", {31'b0, tx_enable}, 0);
      ctrl_wr = 1; ctrl_wdata = 8'h80; link_err_evt = 1; step();
      chk("R11 link pending raises eph", {31'b0, int_status[5]}, 1);
      ctrl_wr = 1; ctrl_wdata = 8'h00; link_err_evt = 1; step();
      ctrl_wr = 1; ctrl_wdata = 8'h80; step();
      chk("R11 event beats clear", {31'b0, int_status[5]}, 1);
      ctrl_wr = 1; ctrl_wdata = 8'h00; step();
      ctrl_wr = 1; ctrl_wdata = 8'h80; step();
      chk("R11 cleared by enable low", {31'b0, int_status[5]}, 0);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         rx_nonempty  = $urandom_range(0, 1);
         tx_err_evt   = ($urandom_range(0, 15) == 0);
         tx_empty_evt = ($urandom_range(0, 7) == 0);
         alloc_cmd    = ($urandom_range(0, 7) == 0);
         alloc_done   = ($urandom_range(0, 7) == 0);
         rx_ovrn_evt  = ($urandom_range(0, 7) == 0);
         link_err_evt = ($urandom_range(0, 15) == 0);
         cnt_evt      = 4'($urandom);
         txen_set     = ($urandom_range(0, 7) == 0);
         mask_wr      = ($urandom_range(0, 15) == 0);
         mask_wdata   = 8'($urandom);
         ist_wr       = ($urandom_range(0, 3) == 0);
         ist_wdata    = 8'($urandom);
         ctrl_wr      = ($urandom_range(0, 15) == 0);
         ctrl_wdata   = 8'($urandom);
         stat_rd      = ($urandom_range(0, 63) == 0);
         step();
      end
      finish_run();
   end
endmodule